// File: doc/BRIEF.md
# Pulse Width Measurement Timer Channel

This block is one channel of a timer that measures how long an input pin stays at a chosen level. Software arms it with a one-cycle start strobe. The channel then waits for the edge that begins the level of interest. On that edge it clears a 16-bit counter and counts prescaled ticks. On the opposite edge it latches the count into a capture register, pulses an interrupt for one cycle, and records whether the counter wrapped during that measurement.

After each capture the counter freezes and the channel waits for the next start edge, so it measures pulse after pulse with no further software action. A one-cycle stop strobe disables the channel. The counter and the overflow flag keep their values when the channel stops. The level to measure is chosen by a mode bit, which can only be written while the channel is disabled. The prescaler, the bus decode and any output pin logic sit outside this block.

Top module: `pulse_width_timer`

## Requirements
- R1: After reset, enabled, count, capture value, overflow flag, interrupt and mode are all 0.
- R2: A start strobe sets enabled to 1 on the next clock edge and puts the channel in a wait state. While it waits, an input edge in the capture direction neither starts counting nor captures.
- R3: A start edge clears the count to 0x0000. After that the count rises by one on every clock edge where the tick input is high, and holds on edges where the tick input is low.
- R4: A capture edge copies the current count into the capture output and raises the interrupt for exactly one cycle. The input passes through a two-flop synchronizer, so a pin change acts on the third rising clock edge after it is first sampled. A level held for N sampled cycles with the tick always high therefore captures N-1.
- R5: The count wraps from 0xFFFF to 0x0000. At capture, the overflow flag is set to 1 if a wrap occurred since the last start edge, and is set to 0 otherwise.
- R6: After a capture the count stays frozen at the captured value until the next start edge, and the channel keeps measuring further pulses without a new start strobe.
- R7: A stop strobe clears enabled on the next edge and takes priority over a start strobe in the same cycle. While the channel is disabled, the count and the overflow flag hold, and input edges have no effect.
- R8: Mode value 0 measures the high level: a rising edge starts and a falling edge captures. Mode value 1 measures the low level: a falling edge starts and a rising edge captures.
- R9: A mode write takes effect only while enabled is 0. A mode write while enabled is 1 is ignored, and the mode output keeps its old value.
- R10: The count output shows the live counter value on every cycle while the channel is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-enable tick from the prescaler |
| pin_i | input | 1 | Asynchronous input to measure |
| start_i | input | 1 | One-cycle start strobe |
| stop_i | input | 1 | One-cycle stop strobe |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_i | input | 1 | Mode write data (0 high level, 1 low level) |
| mode_o | output | 1 | Current mode |
| enabled_o | output | 1 | Channel enable status |
| count_o | output | 16 | Live counter value |
| capture_o | output | 16 | Last captured count |
| ovf_o | output | 1 | Overflow flag of the last capture |
| irq_o | output | 1 | One-cycle capture interrupt |

## Verification
The assertions assume that start and stop are single-cycle strobes. They also assume that the pin stays stable long enough for the synchronizer to see every change, since a glitch shorter than one clock may be lost. The bench drives every input on the falling clock edge and asserts each strobe for exactly one cycle. Each pin level is held for at least several cycles, which keeps every checked edge visible and makes the expected capture value exact.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } phase_e;

    localparam logic MODE_HIGH = 1'b0;
    localparam logic MODE_LOW  = 1'b1;
endpackage

// File: rtl/pwt_sync.sv
module pwt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwt_edge.sv
module pwt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;
    assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/pwt_ctrl.sv
module pwt_ctrl
    import pwt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          rise_i,
    input  logic          fall_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          mode_wr_i,
    input  logic          mode_i,
    output logic          mode_o,
    output logic          enabled_o,
    output logic [CW-1:0] count_o,
    output logic [CW-1:0] capture_o,
    output logic          ovf_o,
    output logic          irq_o
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    typedef struct packed {
        phase_e        phase;
        logic          mode;
        logic [CW-1:0] cnt;
        logic          wrapped;
        logic [CW-1:0] cap;
        logic          ovf;
        logic          irq;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  begin_edge, end_edge;

    always_comb begin
        begin_edge = (s_q.mode == MODE_LOW) ? fall_i : rise_i;
        end_edge   = (s_q.mode == MODE_LOW) ? rise_i : fall_i;

        s_d     = s_q;
        s_d.irq = 1'b0;

        if (mode_wr_i && (s_q.phase == ST_OFF)) begin
            s_d.mode = mode_i;
        end

        if (stop_i) begin
            s_d.phase = ST_OFF;
        end else if (start_i) begin
            s_d.phase = ST_ARMED;
        end else begin
            unique case (s_q.phase)
                ST_ARMED: begin
                    if (begin_edge) begin
                        s_d.cnt     = '0;
                        s_d.wrapped = 1'b0;
                        s_d.phase   = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (end_edge) begin
                        s_d.cap   = s_q.cnt;
                        s_d.ovf   = s_q.wrapped;
                        s_d.irq   = 1'b1;
                        s_d.phase = ST_ARMED;
                    end else if (tick_i) begin
                        s_d.cnt = s_q.cnt + 1'b1;
                        if (s_q.cnt == CNT_MAX) begin
                            s_d.wrapped = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase   <= ST_OFF;
            s_q.mode    <= MODE_HIGH;
            s_q.cnt     <= '0;
            s_q.wrapped <= 1'b0;
            s_q.cap     <= '0;
            s_q.ovf     <= 1'b0;
            s_q.irq     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_o    = s_q.mode;
    assign enabled_o = (s_q.phase != ST_OFF);
    assign count_o   = s_q.cnt;
    assign capture_o = s_q.cap;
    assign ovf_o     = s_q.ovf;
    assign irq_o     = s_q.irq;
endmodule

// File: rtl/pulse_width_timer.sv
module pulse_width_timer #(
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          pin_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          mode_wr_i,
    input  logic          mode_i,
    output logic          mode_o,
    output logic          enabled_o,
    output logic [CW-1:0] count_o,
    output logic [CW-1:0] capture_o,
    output logic          ovf_o,
    output logic          irq_o
);
    logic pin_sync, pin_rise, pin_fall;

    pwt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    pwt_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (pin_sync),
        .rise_o  (pin_rise),
        .fall_o  (pin_fall)
    );

    pwt_ctrl #(.CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .rise_i    (pin_rise),
        .fall_i    (pin_fall),
        .start_i   (start_i),
        .stop_i    (stop_i),
        .mode_wr_i (mode_wr_i),
        .mode_i    (mode_i),
        .mode_o    (mode_o),
        .enabled_o (enabled_o),
        .count_o   (count_o),
        .capture_o (capture_o),
        .ovf_o     (ovf_o),
        .irq_o     (irq_o)
    );
endmodule

// File: rtl/pwt_checker.sv
module pwt_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          stop_i,
    input logic          mode_o,
    input logic          enabled_o,
    input logic [CW-1:0] count_o,
    input logic [CW-1:0] capture_o,
    input logic          ovf_o,
    input logic          irq_o
);
    AST_START_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> enabled_o);                                  // R2
    AST_STOP_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !enabled_o);                                               // R7
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled_o |=> ($stable(count_o) && $stable(ovf_o)));                 // R7
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);                                                    // R4
    AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (capture_o == $past(count_o)));                             // R4
    AST_OVF_ONLY_AT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> $stable(ovf_o));                                           // R5
    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        enabled_o |=> $stable(mode_o));                                       // R9
    AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> (count_o == $past(count_o) || count_o == '0));               // R6
endmodule

bind pulse_width_timer pwt_checker #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .mode_o    (mode_o),
    .enabled_o (enabled_o),
    .count_o   (count_o),
    .capture_o (capture_o),
    .ovf_o     (ovf_o),
    .irq_o     (irq_o)
);

// File: tb/tb_pulse_width_timer.sv
`timescale 1ns/1ps
module tb_pulse_width_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b1;
    logic        pin_i = 1'b0;
    logic        start_i = 1'b0;
    logic        stop_i = 1'b0;
    logic        mode_wr_i = 1'b0;
    logic        mode_i = 1'b0;
    logic        mode_o, enabled_o, ovf_o, irq_o;
    logic [15:0] count_o, capture_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pulse_width_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pin_i(pin_i),
        .start_i(start_i), .stop_i(stop_i), .mode_wr_i(mode_wr_i), .mode_i(mode_i),
        .mode_o(mode_o), .enabled_o(enabled_o), .count_o(count_o),
        .capture_o(capture_o), .ovf_o(ovf_o), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk) stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
    endtask

    task automatic write_mode(input logic m);
        @(negedge clk) begin mode_wr_i = 1'b1; mode_i = m; end
        @(negedge clk) mode_wr_i = 1'b0;
    endtask

    // Hold pin at lvl for n sampled cycles, then return it; check irq and capture.
    task automatic pulse(input logic lvl, input int n, input string req);
        @(negedge clk) pin_i = lvl;
        wait_n(n);
        pin_i = ~lvl;
        wait_n(2);
        chk(irq_o == 1'b0, req, irq_o, 0);
        wait_n(1);
        chk(irq_o == 1'b1, req, irq_o, 1);
        wait_n(1);
        chk(irq_o == 1'b0, req, irq_o, 0);
        chk(capture_o == 16'((n - 1) % 65536), req, capture_o, (n - 1) % 65536);
    endtask

    task automatic t_reset();
        chk(enabled_o == 0 && count_o == 0 && capture_o == 0, "R1", count_o, 0);
        chk(ovf_o == 0 && irq_o == 0 && mode_o == 0, "R1", {ovf_o, irq_o, mode_o}, 0);
    endtask

    task automatic t_wait_ignore();
        @(negedge clk) pin_i = 1'b1;
        wait_n(5);
        do_start();
        chk(enabled_o == 1, "R2", enabled_o, 1);
        @(negedge clk) pin_i = 1'b0;
        wait_n(6);
        chk(count_o == 0 && irq_o == 0, "R2", count_o, 0);
    endtask

    task automatic t_high_basic();
        pulse(1'b1, 10, "R8");
        chk(ovf_o == 0, "R5", ovf_o, 0);
        pulse(1'b1, 37, "R4");
    endtask

    task automatic t_live_count();
        @(negedge clk) pin_i = 1'b1;
        wait_n(3 + 5);
        chk(count_o == 5, "R10", count_o, 5);
        wait_n(7);
        chk(count_o == 12, "R3", count_o, 12);
        pin_i = 1'b0;
        wait_n(4);
        chk(capture_o == 14, "R4", capture_o, 14);
    endtask

    task automatic t_freeze();
        wait_n(20);
        chk(count_o == 14, "R6", count_o, 14);
        pulse(1'b1, 6, "R6");
    endtask

    task automatic t_tick_gate();
        @(negedge clk) begin tick_i = 1'b0; pin_i = 1'b1; end
        wait_n(3 + 8);
        chk(count_o == 0, "R3", count_o, 0);
        tick_i = 1'b1;
        wait_n(4);
        chk(count_o == 4, "R3", count_o, 4);
        pin_i = 1'b0;
        wait_n(4);
        chk(capture_o == 6, "R3", capture_o, 6);
    endtask

    task automatic t_overflow();
        pulse(1'b1, 65536 + 10, "R5");
        chk(ovf_o == 1, "R5", ovf_o, 1);
        pulse(1'b1, 20, "R5");
        chk(ovf_o == 0, "R5", ovf_o, 0);
    endtask

    task automatic t_mode_lock();
        write_mode(1'b1);
        chk(mode_o == 0, "R9", mode_o, 0);
    endtask

    task automatic t_stop_hold();
        @(negedge clk) pin_i = 1'b1;
        wait_n(3 + 9);
        stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
        chk(enabled_o == 0, "R7", enabled_o, 0);
        chk(count_o == 9, "R7", count_o, 9);
        pin_i = 1'b0;
        wait_n(10);
        chk(count_o == 9 && irq_o == 0 && capture_o == 19, "R7", count_o, 9);
        chk(ovf_o == 0, "R7", ovf_o, 0);
    endtask

    task automatic t_both_strobes();
        @(negedge clk) begin start_i = 1'b1; stop_i = 1'b1; end
        @(negedge clk) begin start_i = 1'b0; stop_i = 1'b0; end
        chk(enabled_o == 0, "R7", enabled_o, 0);
    endtask

    task automatic t_low_mode();
        @(negedge clk) pin_i = 1'b1;
        wait_n(5);
        write_mode(1'b1);
        chk(mode_o == 1, "R9", mode_o, 1);
        do_start();
        pulse(1'b0, 25, "R8");
        @(negedge clk) pin_i = 1'b1;
        wait_n(4);
        pulse(1'b0, 3, "R8");
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_wait_ignore();
        t_high_basic();
        t_live_count();
        t_freeze();
        t_tick_gate();
        t_overflow();
        t_mode_lock();
        t_stop_hold();
        t_both_strobes();
        t_low_mode();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule